// File: doc/BRIEF.md
# Subtract-and-Branch Single-Instruction Core

This block is a tiny processor whose only operation is "subtract, then branch if the result is not positive". It has no opcode field. Each instruction is three consecutive words in memory, read in order as operands a, b and c. The core subtracts the word stored at address a from the word stored at address b and writes the difference back to address b. If the difference, read as a signed number, is zero or negative, the program counter takes the value c. Otherwise it steps past the triple to the next one. The machine stops as soon as the program counter holds a negative value.

The core reaches its memory through one synchronous word port with a fixed latency of one cycle. That port is not a stream. A request in one cycle returns its read data in the next, and it never stalls, so it carries no valid/ready pair and no back-pressure. The start input, the halted flag and the cycle counter are plain level signals. Something outside the core preloads the memory while the core is idle.

Top module: `sbn_core`

## Requirements
- R1: While reset is held and in the idle state after reset, `halted` is 0, `mem_req` is 0 and `cyc_count` is 0.
- R2: An instruction at program counter p makes exactly six memory cycles, in this order: read p, read p+1, read p+2 (these give a, b, c), read a, read b, then write b. There are no idle cycles between consecutive instructions.
- R3: The value written to address b is mem[b] − mem[a], wrapped modulo 2^DATA_W. For example, 0x8000 − 1 = 0x7FFF and 0x7FFF − 0xFFFF = 0x8000.
- R4: When the written value is zero or has its most significant bit set, the next instruction is fetched from address c.
- R5: When the written value is greater than zero as a signed number, the next instruction is fetched from p+3.
- R6: A program counter with its most significant bit set causes no memory access. `halted` rises one cycle after the program counter becomes negative and stays at 1 until reset. A `start` pulse while halted has no effect.
- R7: `cyc_count` is cleared by an accepted start. It then increments once for every cycle the core is running. After a run of N instructions it stops at 6·N+1 and holds that value while halted.
- R8: A `start` pulse while the core is running is ignored, and the access trace and cycle count are unchanged.
- R9: `mem_we` is asserted only together with `mem_req`, only in the write cycle of an instruction, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin execution at START_PC; accepted only when idle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | DATA_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| halted | output | 1 | Sticky stop flag |
| cyc_count | output | CNT_W | Running-cycle counter |

## Verification
The bench builds the core with 16-bit words, START_PC at 0, a 20-bit wrapping cycle counter and a 256-word memory model. With a 16-bit word, the sign boundaries 0x7FFF/0x8000 and the halt targets 0x8000 and 0xFFFF are all reachable with small literal programs. A reference model of the instruction rule predicts every memory access for four programs. Together these programs cover a positive result, a zero result, a negative result, wrap-around in both directions, a counted loop, a mid-run start pulse and a start pulse after halting.

// File: rtl/sbn_pkg.sv
package sbn_pkg;

  // Execution phases, one memory cycle each
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FA   = 3'd1,  // request word p   (or halt when p < 0)
    ST_FB   = 3'd2,  // request word p+1, capture a
    ST_FC   = 3'd3,  // request word p+2, capture b
    ST_RA   = 3'd4,  // request mem[a],   capture c
    ST_RB   = 3'd5,  // request mem[b],   capture mem[a]
    ST_WR   = 3'd6,  // write difference, update p
    ST_HALT = 3'd7
  } sbn_state_t;

  function automatic logic is_running(sbn_state_t s);
    return (s != ST_IDLE) && (s != ST_HALT);
  endfunction

endpackage

// File: rtl/sbn_seq.sv
module sbn_seq
  import sbn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pc_neg,
  output sbn_state_t state,
  output logic       go
);

  sbn_state_t state_d;

  assign go = (state == ST_IDLE) && start;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (start) state_d = ST_FA;
      ST_FA:   state_d = pc_neg ? ST_HALT : ST_FB;
      ST_FB:   state_d = ST_FC;
      ST_FC:   state_d = ST_RA;
      ST_RA:   state_d = ST_RB;
      ST_RB:   state_d = ST_WR;
      ST_WR:   state_d = ST_FA;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/sbn_alu.sv
module sbn_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  output logic [DATA_W-1:0] diff,
  output logic              leq
);

  localparam int MSB = DATA_W - 1;

  logic is_zero;

  assign diff    = minuend - subtrahend;
  assign is_zero = (diff == '0);
  assign leq     = diff[MSB] | is_zero;

endmodule

// File: rtl/sbn_dp.sv
module sbn_dp
  import sbn_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int unsigned START_PC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sbn_state_t        state,
  input  logic              go,
  input  logic [DATA_W-1:0] rdata,
  input  logic              leq,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] opa,
  output logic              pc_neg
);

  localparam int                MSB   = DATA_W - 1;
  localparam logic [DATA_W-1:0] PC0   = DATA_W'(START_PC);
  localparam logic [DATA_W-1:0] STEP1 = DATA_W'(1);
  localparam logic [DATA_W-1:0] STEP2 = DATA_W'(2);
  localparam logic [DATA_W-1:0] STEP3 = DATA_W'(3);

  logic [DATA_W-1:0] pc_q, a_q, b_q, c_q, opa_q;

  assign pc_neg = pc_q[MSB];
  assign opa    = opa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= PC0;
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      opa_q <= '0;
    end else begin
      if (go) pc_q <= PC0;
      unique case (state)
        ST_FB: a_q   <= rdata;
        ST_FC: b_q   <= rdata;
        ST_RA: c_q   <= rdata;
        ST_RB: opa_q <= rdata;
        ST_WR: pc_q  <= leq ? c_q : pc_q + STEP3;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_FB:   addr = pc_q + STEP1;
      ST_FC:   addr = pc_q + STEP2;
      ST_RA:   addr = a_q;
      ST_RB:   addr = b_q;
      ST_WR:   addr = b_q;
      default: addr = pc_q;
    endcase
  end

endmodule

// File: rtl/sbn_cyc.sv
module sbn_cyc #(
  parameter int CNT_W    = 32,
  parameter bit SATURATE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_inc;

  generate
    if (SATURATE) begin : g_sat
      assign count_inc = (&count) ? count : count + CNT_W'(1);
    end else begin : g_wrap
      assign count_inc = count + CNT_W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (run)   count <= count_inc;
  end

endmodule

// File: rtl/sbn_core.sv
module sbn_core
  import sbn_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          CNT_W    = 32,
  parameter int unsigned START_PC = 0,
  parameter bit          SATURATE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [CNT_W-1:0]  cyc_count
);

  sbn_state_t        state;
  logic              go;
  logic              pc_neg;
  logic              leq;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] diff;

  sbn_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .pc_neg (pc_neg),
    .state  (state),
    .go     (go)
  );

  sbn_dp #(.DATA_W(DATA_W), .START_PC(START_PC)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state),
    .go     (go),
    .rdata  (mem_rdata),
    .leq    (leq),
    .addr   (mem_addr),
    .opa    (opa),
    .pc_neg (pc_neg)
  );

  // minuend is mem[b], arriving in the write cycle
  sbn_alu #(.DATA_W(DATA_W)) u_alu (
    .minuend    (mem_rdata),
    .subtrahend (opa),
    .diff       (diff),
    .leq        (leq)
  );

  sbn_cyc #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (go),
    .run   (is_running(state)),
    .count (cyc_count)
  );

  assign mem_req   = ((state == ST_FA) && !pc_neg) ||
                     (is_running(state) && (state != ST_FA));
  assign mem_we    = (state == ST_WR);
  assign mem_wdata = diff;
  assign halted    = (state == ST_HALT);

endmodule

// File: rtl/sbn_core_chk.sv
module sbn_core_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              halted,
  input logic [CNT_W-1:0]  cyc_count
);

  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);

  // R7
  halt_count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(cyc_count));

  // R9
  write_is_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  // R9
  write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R3
  write_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == mem_rdata - $past(mem_rdata)));

endmodule

bind sbn_core sbn_core_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .halted    (halted),
  .cyc_count (cyc_count)
);

// File: tb/sim_sbn_core.sv
module sim_sbn_core;

  localparam int DW = 16;
  localparam int CW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mem_req, mem_we, halted;
  logic [DW-1:0] mem_addr, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [CW-1:0] cyc_count;

  always #5 clk = ~clk;

  sbn_core #(.DATA_W(DW), .CNT_W(CW), .START_PC(0), .SATURATE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .cyc_count(cyc_count)
  );

  logic [DW-1:0] mem   [256];
  logic [DW-1:0] ref_m [256];

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= mem[mem_addr[7:0]];
      if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
    end
  end

  int n_cmp = 0;
  int n_bad = 0;
  int exp_cyc = 0;

  bit            q_we   [$];
  logic [DW-1:0] q_addr [$];
  logic [DW-1:0] q_data [$];
  string         q_tag  [$];

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic push(bit we, logic [DW-1:0] a, logic [DW-1:0] d, string tg);
    q_we.push_back(we);
    q_addr.push_back(a);
    q_data.push_back(d);
    q_tag.push_back(tg);
  endtask

  // Scoreboard monitor: every access is compared against the next expected item
  bit            e_we;
  logic [DW-1:0] e_addr, e_data;
  string         e_tag;
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (q_addr.size() == 0) begin
        chk(1'b0, "R6", "unexpected access", mem_addr, 0);
      end else begin
        e_we   = q_we.pop_front();
        e_addr = q_addr.pop_front();
        e_data = q_data.pop_front();
        e_tag  = q_tag.pop_front();
        chk(mem_we == e_we, "R9", "write enable", mem_we, e_we);
        chk(mem_addr == e_addr, e_tag, "access address", mem_addr, e_addr);
        if (e_we) chk(mem_wdata == e_data, "R3", "write data", mem_wdata, e_data);
      end
    end
  end

  task automatic put(int a, int v);
    mem[a]   = DW'(v);
    ref_m[a] = DW'(v);
  endtask

  // Reference model of the instruction rule; fills the scoreboard
  task automatic predict();
    logic [DW-1:0] pc, a, b, c, d, p1, p2;
    string tg;
    int n;
    pc = '0;
    tg = "R2";
    n = 0;
    while (!pc[DW-1] && n < 500) begin
      p1 = pc + 16'd1;
      p2 = pc + 16'd2;
      a = ref_m[pc[7:0]];
      b = ref_m[p1[7:0]];
      c = ref_m[p2[7:0]];
      push(1'b0, pc, '0, tg);
      push(1'b0, p1, '0, "R2");
      push(1'b0, p2, '0, "R2");
      push(1'b0, a, '0, "R2");
      push(1'b0, b, '0, "R2");
      d = ref_m[b[7:0]] - ref_m[a[7:0]];
      ref_m[b[7:0]] = d;
      push(1'b1, b, d, "R3");
      if ($signed(d) <= 0) begin pc = c; tg = "R4"; end
      else begin pc = pc + 16'd3; tg = "R5"; end
      n++;
    end
    exp_cyc = 6 * n + 1;
  endtask

  task automatic load(int id);
    for (int i = 0; i < 256; i++) put(i, 0);
    case (id)
      0: begin // negative result, halt through c = 0xFFFF
        put(0, 100); put(1, 101); put(2, 16'hFFFF);
        put(100, 5); put(101, 3);
      end
      1: begin // positive then zero result
        put(0, 100); put(1, 101); put(2, 50);
        put(3, 102); put(4, 101); put(5, 16'hFFF0);
        put(100, 1); put(101, 3); put(102, 2);
      end
      2: begin // wrap in both directions
        put(0, 101); put(1, 100); put(2, 16'hFFFF);
        put(3, 103); put(4, 104); put(5, 6);
        put(6, 102); put(7, 102); put(8, 16'h9000);
        put(100, 16'h8000); put(101, 1); put(102, 7);
        put(103, 16'hFFFF); put(104, 16'h7FFF);
      end
      default: begin // counted loop
        put(0, 101); put(1, 100); put(2, 6);
        put(3, 102); put(4, 102); put(5, 0);
        put(6, 102); put(7, 102); put(8, 16'hFFFF);
        put(100, 4); put(101, 1);
      end
    endcase
  endtask

  task automatic run_prog(int id, bit mid_start);
    logic [CW-1:0] held;
    rst_n = 1'b0;
    load(id);
    repeat (3) @(negedge clk);
    chk(halted == 1'b0, "R1", "halted in reset", halted, 0);
    chk(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
    chk(cyc_count == '0, "R1", "count in reset", cyc_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1'b0 && halted == 1'b0, "R1", "idle outputs", {mem_req, halted}, 0);
    predict();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_start) begin
      repeat (9) @(negedge clk);
      start = 1'b1; // R8: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!halted) @(negedge clk);
    chk(cyc_count == CW'(exp_cyc), mid_start ? "R8" : "R7", "final count",
        cyc_count, exp_cyc);
    chk(q_addr.size() == 0, "R2", "accesses left over", q_addr.size(), 0);
    held = cyc_count;
    start = 1'b1; // R6: start while halted has no effect
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    chk(halted == 1'b1, "R6", "halted sticky", halted, 1);
    chk(cyc_count == held, "R7", "count held after halt", cyc_count, held);
    q_we.delete(); q_addr.delete(); q_data.delete(); q_tag.delete();
  endtask

  initial begin
    run_prog(0, 1'b0);
    run_prog(1, 1'b0);
    run_prog(2, 1'b0);
    run_prog(3, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R6 watchdog expired: actual running expected halted");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule